// File: doc/BRIEF.md
# Edge-Interrupt GPIO Register Bank

This block is a memory-mapped GPIO controller for 32 pins, arranged as four ports of eight pins. Each pin has a direction bit and an output data bit. Each pin also has a two-bit interrupt mode field, and one value of that field turns the pin's interrupt off. Pad inputs pass through a two-flop synchronizer. Edges are found on the synchronized value and latched into a status register, which software clears by writing ones to it. A single level interrupt output goes to a parent interrupt controller.

A strap input selects where each port sits inside a register word. In normal order, port 0 is in the lowest byte lane. In reversed order, the ports are mirrored. The mode registers also swap the halfwords within each word.

The register port is synchronous. The address is a word index, each data byte has its own strobe, and a halfword access sets two strobes. Read data appears one cycle after the request.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, direction, output data, all mode fields and all status bits are zero. `pad_oe_o` and `irq_o` are low, and every mapped register reads zero.
- R2: A direction bit of 1 makes the pin an output: `pad_oe_o` goes high and `pad_o` drives the stored data bit. A direction bit of 0 makes the pin an input. Direction changes only when the direction word (index 2) is written.
- R3: The data word (index 3) reads back the stored data bit for output pins. For input pins it reads the pad value after the two synchronizer flops.
- R4: Pin n of a port uses bits 2n+1:2n of that port's 16-bit mode field. A value of 0 latches no edge, 1 latches falling edges, 2 latches rising edges and 3 latches both. An event sets the pin's bit in the status word (index 4).
- R5: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R6: If a new edge and a clear reach the same status bit in the same cycle, the bit stays set.
- R7: `irq_o` is the OR of the status bits whose pin has a nonzero mode field. Setting a mode field to 0 drops that pin's contribution but keeps its status bit.
- R8: Normal order (`rev_order_i`=0): port p sits in bits 8p+7:8p of the direction, data and status words. Ports 0 and 1 use the low and high halfwords of mode word index 5, and ports 2 and 3 use the low and high halfwords of index 6.
- R9: Reversed order (`rev_order_i`=1): port p sits in byte lane 3-p. Mode word 5 holds port 1 in its low halfword and port 0 in its high halfword. Mode word 6 holds port 3 low and port 2 high.
- R10: A write changes only the byte lanes whose `be_i` bit is set. Strobe bit b covers `wdata_i` bits 8b+7:8b.
- R11: A pad change appears on `irq_o` and in the status bit after three rising edges. Read data is valid one cycle after the read request.
- R12: Word indices 0 and 1 read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rev_order_i | input | 1 | Strap: 1 selects reversed port order |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Word index (byte offset / 4) |
| be_i | input | 4 | Byte lane strobes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after request |
| pad_i | input | 32 | Pad input levels |
| pad_o | output | 32 | Pad output levels |
| pad_oe_o | output | 32 | Pad output enables |
| irq_o | output | 1 | Combined interrupt to parent |

## Verification
Two things can reach the same status bit in one cycle: an edge detected on a pin and a software write that clears that bit. The bench lines the two up on purpose. It changes a pad, waits two falling edges, and then issues the clear write, so the write is sampled on the same rising edge that latches the edge. A read that follows must show the bit still set. Before that, a clear with no competing edge shows the bit dropping to zero, so that case is judged against the contended one.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int PORTS  = 4;
  localparam int PIN_W  = 8;
  localparam int NPIN   = PORTS * PIN_W;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int WSEL_W = 3;
  localparam int MODE_W = 2 * PIN_W;

  typedef enum logic [WSEL_W-1:0] {
    WI_DIR     = 3'd2,
    WI_DATA    = 3'd3,
    WI_STAT    = 3'd4,
    WI_MODE_LO = 3'd5,
    WI_MODE_HI = 3'd6
  } word_e;

  function automatic int lane_of(int p, logic rev);
    return rev ? (PORTS - 1 - p) : p;
  endfunction

  // halfword slot of a port's mode field, counted over both mode words
  function automatic int mode_slot(int p, logic rev);
    return rev ? (p ^ 1) : p;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int PIN_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PIN_W-1:0]   sync_i,
  input  logic [2*PIN_W-1:0] mode_i,
  input  logic [PIN_W-1:0]   clr_i,
  output logic [PIN_W-1:0]   status_o,
  output logic [PIN_W-1:0]   active_o
);
  logic [PIN_W-1:0] prev_q, status_q, rise, fall, set;

  assign rise = sync_i & ~prev_q;
  assign fall = ~sync_i & prev_q;

  for (genvar n = 0; n < PIN_W; n++) begin : g_pin
    assign set[n]      = (rise[n] & mode_i[2*n+1]) | (fall[n] & mode_i[2*n]);
    assign active_o[n] = |mode_i[2*n +: 2];

    assert_no_set_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_q[n]) |-> $past(mode_i[2*n +: 2]) != 2'b00);

    assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[n] && !set[n]) |=> !status_q[n]);

    assert_edge_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set[n] |=> status_q[n]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= sync_i;
      status_q <= (status_q & ~clr_i) | set;  // new edge beats clear
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rev_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [WSEL_W-1:0] wsel_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NPIN-1:0]   pin_in_i,
  input  logic [NPIN-1:0]   status_i,
  output logic [NPIN-1:0]   dir_o,
  output logic [NPIN-1:0]   dout_o,
  output logic [PORTS*MODE_W-1:0] mode_o,
  output logic [NPIN-1:0]   clr_o
);
  logic [NPIN-1:0]         dir_q, dout_q;
  logic [PORTS*MODE_W-1:0] mode_q;
  logic [DATA_W-1:0]       rdata_q, rd;
  logic [1:0]              lane_w  [PORTS];
  logic [WSEL_W-1:0]       mword_w [PORTS];
  logic                    mhalf_w [PORTS];
  logic                    wr;

  assign wr = req_i & we_i;

  for (genvar p = 0; p < PORTS; p++) begin : g_map
    assign lane_w[p]  = 2'(lane_of(p, rev_i));
    assign mword_w[p] = WSEL_W'(int'(WI_MODE_LO) + mode_slot(p, rev_i) / 2);
    assign mhalf_w[p] = 1'(mode_slot(p, rev_i) % 2);
    assign clr_o[p*PIN_W +: PIN_W] =
      (wr && wsel_i == WI_STAT && be_i[lane_w[p]]) ?
      wdata_i[int'(lane_w[p])*PIN_W +: PIN_W] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      dout_q <= '0;
      mode_q <= '0;
    end else if (wr) begin
      for (int p = 0; p < PORTS; p++) begin
        if (wsel_i == WI_DIR && be_i[lane_w[p]])
          dir_q[p*PIN_W +: PIN_W] <= wdata_i[int'(lane_w[p])*PIN_W +: PIN_W];
        if (wsel_i == WI_DATA && be_i[lane_w[p]])
          dout_q[p*PIN_W +: PIN_W] <= wdata_i[int'(lane_w[p])*PIN_W +: PIN_W];
        for (int b = 0; b < 2; b++) begin
          if (wsel_i == mword_w[p] && be_i[2*int'(mhalf_w[p]) + b])
            mode_q[p*MODE_W + b*PIN_W +: PIN_W] <=
              wdata_i[(2*int'(mhalf_w[p]) + b)*PIN_W +: PIN_W];
        end
      end
    end
  end

  always_comb begin
    rd = '0;
    for (int p = 0; p < PORTS; p++) begin
      case (wsel_i)
        WI_DIR:  rd[int'(lane_w[p])*PIN_W +: PIN_W] = dir_q[p*PIN_W +: PIN_W];
        WI_DATA: rd[int'(lane_w[p])*PIN_W +: PIN_W] =
                   (dout_q[p*PIN_W +: PIN_W] & dir_q[p*PIN_W +: PIN_W]) |
                   (pin_in_i[p*PIN_W +: PIN_W] & ~dir_q[p*PIN_W +: PIN_W]);
        WI_STAT: rd[int'(lane_w[p])*PIN_W +: PIN_W] = status_i[p*PIN_W +: PIN_W];
        WI_MODE_LO, WI_MODE_HI:
          if (mword_w[p] == wsel_i)
            rd[int'(mhalf_w[p])*MODE_W +: MODE_W] = mode_q[p*MODE_W +: MODE_W];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd;
  end

  assert_dir_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && wsel_i == WI_DIR) |=> $stable(dir_o));

  assert_unmapped_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && wsel_i < WSEL_W'(WI_DIR)) |=>
      ($stable(dir_o) && $stable(dout_o) && $stable(mode_o)));

  assign rdata_o = rdata_q;
  assign dir_o   = dir_q;
  assign dout_o  = dout_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rev_order_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [WSEL_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NPIN-1:0]   pad_i,
  output logic [NPIN-1:0]   pad_o,
  output logic [NPIN-1:0]   pad_oe_o,
  output logic              irq_o
);
  logic [NPIN-1:0]         sync, status, active, clr, dir, dout;
  logic [PORTS*MODE_W-1:0] mode;

  gpio_sync #(.W(NPIN)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pad_i), .q_o(sync)
  );

  gpio_regs i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .rev_i(rev_order_i),
    .req_i(req_i), .we_i(we_i), .wsel_i(addr_i), .be_i(be_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pin_in_i(sync), .status_i(status),
    .dir_o(dir), .dout_o(dout), .mode_o(mode), .clr_o(clr)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    gpio_edge_port #(.PIN_W(PIN_W)) i_port (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .sync_i(sync[p*PIN_W +: PIN_W]),
      .mode_i(mode[p*MODE_W +: MODE_W]),
      .clr_i(clr[p*PIN_W +: PIN_W]),
      .status_o(status[p*PIN_W +: PIN_W]),
      .active_o(active[p*PIN_W +: PIN_W])
    );
  end

  assign irq_o    = |(status & active);
  assign pad_o    = dout;
  assign pad_oe_o = dir;
endmodule

// File: tb/test_gpio_edge_bank.sv
`timescale 1ns/1ps
module test_gpio_edge_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rev = 1'b0, req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0, rdata, pad = '0, pad_o, pad_oe;
  logic        irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_edge_bank i_gpio_edge_bank (
    .clk_i(clk), .rst_ni(rst_n), .rev_order_i(rev), .req_i(req), .we_i(we),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .rdata_o(rdata),
    .pad_i(pad), .pad_o(pad_o), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  typedef struct packed {
    logic        rv;
    logic        wr;
    logic [2:0]  ad;
    logic [3:0]  bs;
    logic [31:0] wd;
    logic [31:0] ex;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 3'd2, 4'hF, 32'h0,        32'h0,        4'd1},  // R1 dir
    '{1'b0, 1'b0, 3'd5, 4'hF, 32'h0,        32'h0,        4'd1},  // R1 mode
    '{1'b0, 1'b1, 3'd2, 4'hF, 32'hA5C30F81, 32'h0,        4'd8},
    '{1'b0, 1'b0, 3'd2, 4'hF, 32'h0,        32'hA5C30F81, 4'd8},  // R8
    '{1'b0, 1'b1, 3'd2, 4'h2, 32'hFFFFFFFF, 32'h0,        4'd10},
    '{1'b0, 1'b0, 3'd2, 4'hF, 32'h0,        32'hA5C3FF81, 4'd10}, // R10
    '{1'b1, 1'b0, 3'd2, 4'hF, 32'h0,        32'h81FFC3A5, 4'd9},  // R9 lanes
    '{1'b1, 1'b1, 3'd5, 4'h3, 32'h00001234, 32'h0,        4'd9},
    '{1'b0, 1'b0, 3'd5, 4'hF, 32'h0,        32'h12340000, 4'd8},  // R8/R9 mode
    '{1'b1, 1'b1, 3'd6, 4'hC, 32'hBEEF0000, 32'h0,        4'd9},
    '{1'b0, 1'b0, 3'd6, 4'hF, 32'h0,        32'h0000BEEF, 4'd9},  // R9
    '{1'b1, 1'b0, 3'd5, 4'hF, 32'h0,        32'h00001234, 4'd9},  // R9
    '{1'b0, 1'b1, 3'd0, 4'hF, 32'hFFFFFFFF, 32'h0,        4'd12},
    '{1'b0, 1'b0, 3'd0, 4'hF, 32'h0,        32'h0,        4'd12}, // R12
    '{1'b0, 1'b0, 3'd1, 4'hF, 32'h0,        32'h0,        4'd12}, // R12
    '{1'b0, 1'b0, 3'd2, 4'hF, 32'h0,        32'hA5C3FF81, 4'd12}, // R12
    '{1'b0, 1'b1, 3'd2, 4'hF, 32'h0,        32'h0,        4'd1},
    '{1'b0, 1'b1, 3'd5, 4'hF, 32'h0,        32'h0,        4'd1},
    '{1'b0, 1'b1, 3'd6, 4'hF, 32'h0,        32'h0,        4'd1}
  };

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge with rdata valid
  task automatic bus(logic rv, logic w, logic [2:0] a, logic [3:0] b, logic [31:0] d);
    rev = rv; req = 1'b1; we = w; addr = a; be = b; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    bus(0, 0, 3'd4, 4'hF, 0); chk("R1 status", rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus(TBL[i].rv, TBL[i].wr, TBL[i].ad, TBL[i].bs, TBL[i].wd);
      if (!TBL[i].wr) chk($sformatf("R%0d vec%0d", TBL[i].rq, i), rdata, TBL[i].ex);
    end

    // R2 direction and output drive
    bus(0, 1, 3'd2, 4'hF, 32'h000000FF);
    bus(0, 1, 3'd3, 4'hF, 32'h0000005A);
    chk("R2 pad_oe", pad_oe, 32'h000000FF);
    chk("R2 pad_o", pad_o, 32'h0000005A);

    // R3 readback mixes driven and synchronized values
    pad = 32'h00003C00; cyc(3);
    bus(0, 0, 3'd3, 4'hF, 0); chk("R3 data", rdata, 32'h00003C5A);

    // R4 modes on port 1: pin0 fall, pin1 rise, pin2 both, pin3 off
    pad = 32'h0; cyc(3);
    bus(0, 1, 3'd5, 4'hC, 32'h00390000);
    pad = 32'h00000F00;
    cyc(2); chk("R11 irq early", {31'h0, irq}, 32'h0);
    cyc(1); chk("R11 irq on time", {31'h0, irq}, 32'h1);
    bus(0, 0, 3'd4, 4'hF, 0); chk("R4 rise", rdata, 32'h00000600);
    bus(0, 1, 3'd4, 4'hF, 32'hFFFFFFFF);
    bus(0, 0, 3'd4, 4'hF, 0); chk("R5 clear all", rdata, 32'h0);
    chk("R7 irq low", {31'h0, irq}, 32'h0);
    pad = 32'h0; cyc(3);
    bus(0, 0, 3'd4, 4'hF, 0); chk("R4 fall", rdata, 32'h00000500);

    // R7 mode off masks irq but keeps status
    bus(0, 1, 3'd5, 4'hC, 32'h0);
    chk("R7 irq masked", {31'h0, irq}, 32'h0);
    bus(0, 0, 3'd4, 4'hF, 0); chk("R7 status kept", rdata, 32'h00000500);
    bus(0, 1, 3'd5, 4'hC, 32'h00390000);
    chk("R7 irq back", {31'h0, irq}, 32'h1);

    // R5 write one clears, zeros keep; R10 strobe gates clear
    bus(0, 1, 3'd4, 4'hF, 32'h00000100);
    bus(0, 0, 3'd4, 4'hF, 0); chk("R5 partial", rdata, 32'h00000400);
    bus(0, 1, 3'd4, 4'h1, 32'h00000400);
    bus(0, 0, 3'd4, 4'hF, 0); chk("R10 no lane", rdata, 32'h00000400);
    bus(1, 0, 3'd4, 4'hF, 0); chk("R9 status rev", rdata, 32'h00040000);
    bus(0, 1, 3'd4, 4'h2, 32'h00000400);
    bus(0, 0, 3'd4, 4'hF, 0); chk("R10 lane cleared", rdata, 32'h0);

    // R6 clear and edge on the same rising edge
    pad = 32'h00000400;
    cyc(2);
    bus(0, 1, 3'd4, 4'hF, 32'h00000400);
    bus(0, 0, 3'd4, 4'hF, 0); chk("R6 edge wins", rdata, 32'h00000400);
    chk("R6 irq", {31'h0, irq}, 32'h1);
    bus(0, 1, 3'd4, 4'hF, 32'h00000400);
    bus(0, 0, 3'd4, 4'hF, 0); chk("R5 clear after", rdata, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule